// File: doc/BRIEF.md
# Abstract command launcher with data-word auto-execute

This block sits inside a processor debug module and carries out abstract register-access commands for a host debugger. The host reaches it over a small register bus that carries an address, a valid strobe, a write flag and a data word. When a command arrives, the block moves one value between data word 0 and a named core register through a request/acknowledge handshake. If the command asks for it, a second handshake then starts the program buffer, and it always does so after the register move has been acknowledged.

An auto-execute control bit makes every host read or write of data word 0 run the stored command again. A host can stream memory with this. Command zero copies a scratch register into data word 0, and the program buffer then loads the next word into that register and advances a pointer. Each later read of data word 0 returns the previous result and starts the next step, so the data reaches the host two accesses behind the memory loads.

A sticky error field in the status register reports misuse. The error is set when data word 0 or the command register is touched while a command is still running, or when the command cannot be executed. Writing ones to the field clears it. While the field is nonzero, no command starts.

Top module: `acmd_autoexec_ctrl`

## Requirements
- R1: After reset, the status word (address 0x16) reads 0, data word 0 (address 0x04), the command register (0x17) and the auto-execute register (0x18) read 0, and neither core request is asserted.
- R2: A host write to the command register while idle with no error stored launches the command. If the command has the transfer flag (bit 17) set, the transfer request is asserted from the next cycle. Busy (status bit 12) stays high whenever a core request is asserted.
- R3: With transfer set, the register number is taken from bits 15:0. When the write flag (bit 16) is clear, the core register value is captured into data word 0 on the transfer acknowledge. When the write flag is set, data word 0 is driven to the core as the value to store.
- R4: When postexec (bit 18) is also set, the program-buffer request rises only after the transfer has been acknowledged, and the two requests are never asserted together.
- R5: Busy stays high until the last acknowledge of the command (transfer, or program-buffer run if postexec is set) and falls in the following cycle.
- R6: When bit 0 of the auto-execute register is 1, each host read or write of data word 0 made while idle with no error stored runs the stored command again. When the bit is 0, an access to data word 0 starts nothing. Bit 0 reads back.
- R7: A host read of data word 0 returns the value held before the command it triggers updates data word 0. This gives the two-deep streaming lag: the k-th triggered read (k at least 2) returns the memory word loaded k-2 steps after the first.
- R8: A host access to data word 0 or the command register while busy sets the error field (status bits 10:8) to 1 if it was 0. The access starts nothing, and a write to data word 0 made then is dropped.
- R9: The error field is sticky: writing 0 leaves it unchanged, and writing ones to bits 10:8 of the status word clears those bits. While it is nonzero, command-register writes and data-word-0 accesses launch nothing.
- R10: A command whose type field (bits 31:24) is not 0, or which has transfer set with a size field (bits 22:20) other than 2 (32-bit), sets the error field to 2 and leaves busy low. A postexec-only command runs whatever its size field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_valid | input | 1 | Host access strobe, one access per cycle |
| hst_write | input | 1 | 1 for a write, 0 for a read |
| hst_addr | input | AW | Host word address |
| hst_wdata | input | W | Host write data |
| hst_rdata | output | W | Read data for the addressed register, combinational |
| core_xfer_req | output | 1 | Register move request, held until acknowledged |
| core_xfer_write | output | 1 | 1: store core_xfer_wdata into the register; 0: return its value |
| core_xfer_regno | output | 16 | Core register number |
| core_xfer_wdata | output | W | Value to store (data word 0) |
| core_xfer_rdata | input | W | Register value returned with the acknowledge |
| core_xfer_ack | input | 1 | One-cycle acknowledge of the register move |
| core_exec_req | output | 1 | Program-buffer run request, held until acknowledged |
| core_exec_ack | input | 1 | One-cycle acknowledge that the run has finished |

## Verification
The assertions check on every cycle that the two core requests are exclusive and correctly ordered, that busy covers every request and falls exactly one cycle after the final acknowledge, and that a busy-time access, an unsupported command or a stored error produces the right error value with no launch. The following can only be shown by the bench scenarios, which run against a core model whose program buffer loads a computed memory word and advances a pointer: the data values that cross the handshake, the one-access lag of data word 0 and the resulting two-deep memory stream, the dropping of a write made while busy, and the sticky write-ones-to-clear behaviour of the error field.

// File: rtl/acmd_pkg.sv
package acmd_pkg;

  localparam int CMD_W   = 32;
  localparam int REGNO_W = 16;
  localparam int ERR_W   = 3;

  localparam logic [ERR_W-1:0] ERR_NONE  = 3'd0;
  localparam logic [ERR_W-1:0] ERR_BUSY  = 3'd1;
  localparam logic [ERR_W-1:0] ERR_UNSUP = 3'd2;

  localparam logic [2:0] SIZE_32 = 3'd2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_XFER, SQ_EXEC} sq_state_e;

  typedef struct packed {
    logic               ok;
    logic               transfer;
    logic               postexec;
    logic               write;
    logic [REGNO_W-1:0] regno;
  } cmd_t;

  // Command word: type 31:24, size 22:20, postexec 18, transfer 17, write 16, regno 15:0
  function automatic cmd_t cmd_decode(input logic [CMD_W-1:0] c);
    cmd_t d;
    d.transfer = c[17];
    d.postexec = c[18];
    d.write    = c[16];
    d.regno    = c[15:0];
    d.ok       = (c[31:24] == 8'd0) && (!c[17] || (c[22:20] == SIZE_32));
    return d;
  endfunction

  // Status word: busy at bit 12, error field at 10:8
  function automatic logic [CMD_W-1:0] status_word(input logic busy,
                                                   input logic [ERR_W-1:0] err);
    logic [CMD_W-1:0] s;
    s        = '0;
    s[12]    = busy;
    s[10:8]  = err;
    return s;
  endfunction

  // Sticky error update: a new error only lands on a clean field, ones clear
  function automatic logic [ERR_W-1:0] err_next(input logic [ERR_W-1:0] err,
                                                input logic set_busy,
                                                input logic set_unsup,
                                                input logic clr_en,
                                                input logic [ERR_W-1:0] clr_mask);
    logic [ERR_W-1:0] e;
    e = err;
    if (clr_en) e = e & ~clr_mask;
    if (err == ERR_NONE) begin
      if (set_busy)       e = ERR_BUSY;
      else if (set_unsup) e = ERR_UNSUP;
    end
    return e;
  endfunction

endpackage

// File: rtl/acmd_decode.sv
module acmd_decode
  import acmd_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_word,
  output cmd_t             cmd_info
);
  always_comb cmd_info = cmd_decode(cmd_word);
endmodule

// File: rtl/acmd_seq.sv
module acmd_seq
  import acmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic do_xfer,
  input  logic do_exec,
  input  logic xfer_ack,
  input  logic exec_ack,
  output logic busy,
  output logic xfer_req,
  output logic exec_req,
  output logic xfer_fire,
  output logic seq_done
);
  sq_state_e state_q;
  logic      post_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      post_q  <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: if (start) begin
          post_q <= do_exec;
          if (do_xfer)      state_q <= SQ_XFER;
          else if (do_exec) state_q <= SQ_EXEC;
        end
        SQ_XFER: if (xfer_ack) state_q <= post_q ? SQ_EXEC : SQ_IDLE;
        SQ_EXEC: if (exec_ack) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != SQ_IDLE);
  assign xfer_req  = (state_q == SQ_XFER);
  assign exec_req  = (state_q == SQ_EXEC);
  assign xfer_fire = xfer_req && xfer_ack;
  assign seq_done  = (xfer_fire && !post_q) || (exec_req && exec_ack);
endmodule

// File: rtl/acmd_autoexec_ctrl.sv
module acmd_autoexec_ctrl
  import acmd_pkg::*;
#(
  parameter int            AW        = 7,
  parameter int            W         = 32,
  parameter logic [AW-1:0] A_DATA0   = 'h04,
  parameter logic [AW-1:0] A_STATUS  = 'h16,
  parameter logic [AW-1:0] A_CMD     = 'h17,
  parameter logic [AW-1:0] A_AUTO    = 'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_valid,
  input  logic               hst_write,
  input  logic [AW-1:0]      hst_addr,
  input  logic [W-1:0]       hst_wdata,
  output logic [W-1:0]       hst_rdata,
  output logic               core_xfer_req,
  output logic               core_xfer_write,
  output logic [REGNO_W-1:0] core_xfer_regno,
  output logic [W-1:0]       core_xfer_wdata,
  input  logic [W-1:0]       core_xfer_rdata,
  input  logic               core_xfer_ack,
  output logic               core_exec_req,
  input  logic               core_exec_ack
);
  logic [W-1:0]     data0_q;
  logic [W-1:0]     cmd_q;
  logic             auto_q;
  logic [ERR_W-1:0] err_q;

  // Named events for the checker
  logic busy, xfer_fire, seq_done;
  logic hit_d0, hit_cmd, hit_st, hit_auto;
  logic busy_viol, try_launch, launch, unsup_hit;
  logic [W-1:0] run_word;
  cmd_t run_dec, cur_dec;

  assign hit_d0   = hst_valid && (hst_addr == A_DATA0);
  assign hit_cmd  = hst_valid && hst_write && (hst_addr == A_CMD);
  assign hit_st   = hst_valid && hst_write && (hst_addr == A_STATUS);
  assign hit_auto = hst_valid && hst_write && (hst_addr == A_AUTO);

  assign busy_viol  = (hit_d0 || hit_cmd) && busy;
  assign try_launch = !busy && (hit_cmd || (hit_d0 && auto_q));
  assign run_word   = hit_cmd ? hst_wdata : cmd_q;
  assign launch     = try_launch && (err_q == ERR_NONE) && run_dec.ok;
  assign unsup_hit  = try_launch && (err_q == ERR_NONE) && !run_dec.ok;

  acmd_decode u_dec_run (.cmd_word(run_word), .cmd_info(run_dec));
  acmd_decode u_dec_cur (.cmd_word(cmd_q),    .cmd_info(cur_dec));

  acmd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (launch),
    .do_xfer  (run_dec.transfer),
    .do_exec  (run_dec.postexec),
    .xfer_ack (core_xfer_ack),
    .exec_ack (core_exec_ack),
    .busy     (busy),
    .xfer_req (core_xfer_req),
    .exec_req (core_exec_req),
    .xfer_fire(xfer_fire),
    .seq_done (seq_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data0_q <= '0;
      cmd_q   <= '0;
      auto_q  <= 1'b0;
      err_q   <= ERR_NONE;
    end else begin
      err_q <= err_next(err_q, busy_viol, unsup_hit, hit_st, hst_wdata[10:8]);
      if (hit_auto)                  auto_q <= hst_wdata[0];
      if (hit_cmd && !busy)          cmd_q  <= hst_wdata;
      if (xfer_fire && !cur_dec.write)
        data0_q <= core_xfer_rdata;
      else if (hit_d0 && hst_write && !busy)
        data0_q <= hst_wdata;
    end
  end

  assign core_xfer_write = cur_dec.write;
  assign core_xfer_regno = cur_dec.regno;
  assign core_xfer_wdata = data0_q;

  always_comb begin
    hst_rdata = '0;
    if (hst_addr == A_DATA0)       hst_rdata = data0_q;
    else if (hst_addr == A_STATUS) hst_rdata = status_word(busy, err_q);
    else if (hst_addr == A_CMD)    hst_rdata = cmd_q;
    else if (hst_addr == A_AUTO)   hst_rdata[0] = auto_q;
  end
endmodule

// File: rtl/acmd_checker.sv
module acmd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       xfer_req,
  input logic       xfer_ack,
  input logic       exec_req,
  input logic       seq_done,
  input logic       busy_viol,
  input logic       unsup_hit,
  input logic       post_cur,
  input logic [2:0] err
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_req, exec_req})); // R4
  AST_EXEC_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack && post_cur) |=> exec_req); // R4
  AST_REQ_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req || exec_req) |-> busy); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |=> busy); // R5
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !busy); // R5
  AST_BUSY_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    busy_viol |=> (err != 3'd0)); // R8
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((err != 3'd0) && !busy) |=> !busy); // R9
  AST_UNSUP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_hit |=> ((err == 3'd2) && !busy)); // R10
endmodule

bind acmd_autoexec_ctrl acmd_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .xfer_req (core_xfer_req),
  .xfer_ack (core_xfer_ack),
  .exec_req (core_exec_req),
  .seq_done (seq_done),
  .busy_viol(busy_viol),
  .unsup_hit(unsup_hit),
  .post_cur (cur_dec.postexec),
  .err      (err_q)
);

// File: tb/sim_acmd_autoexec_ctrl.sv
`timescale 1ns/1ps
module sim_acmd_autoexec_ctrl;
  localparam logic [6:0] AD0 = 7'h04, AST = 7'h16, ACM = 7'h17, AAU = 7'h18;
  localparam logic [15:0] RS0 = 16'h1008, RS1 = 16'h1009;

  logic clk = 0, rst_n = 0;
  logic hst_valid = 0, hst_write = 0;
  logic [6:0] hst_addr = 0;
  logic [31:0] hst_wdata = 0, hst_rdata;
  logic xreq, xwr, xack = 0, ereq, eack = 0;
  logic [15:0] xregno;
  logic [31:0] xwdata, xrdata = 0;

  int tests = 0, fails = 0, overlap = 0, hold = 0;
  logic [31:0] creg [16];
  logic [31:0] rd, exp_reg [8];

  always #4 clk = ~clk;

  acmd_autoexec_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_write(hst_write),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .core_xfer_req(xreq), .core_xfer_write(xwr), .core_xfer_regno(xregno),
    .core_xfer_wdata(xwdata), .core_xfer_rdata(xrdata), .core_xfer_ack(xack),
    .core_exec_req(ereq), .core_exec_ack(eack));

  function automatic logic [31:0] mem_at(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0F0F1234;
  endfunction
  function automatic logic [31:0] mk(input logic [7:0] typ, input logic [2:0] sz,
      input logic pe, input logic tr, input logic wr, input logic [15:0] rn);
    return {typ, 1'b0, sz, 1'b0, pe, tr, wr, rn};
  endfunction
  function automatic logic [31:0] st(input logic b, input logic [2:0] e);
    return {19'd0, b, 1'b0, e, 8'd0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Core model: register file plus a program buffer that loads and increments
  initial begin
    int xc = 0, ec = 0;
    for (int i = 0; i < 16; i++) creg[i] = 32'h0;
    forever begin
      @(negedge clk);
      xack = 0; eack = 0;
      if (xreq && ereq) overlap++;
      if (rst_n && xreq) begin
        if (xc >= hold) begin
          xc = 0;
          if (xwr) creg[xregno[3:0]] = xwdata;
          else xrdata = creg[xregno[3:0]];
          xack = 1;
        end else xc++;
      end
      if (rst_n && ereq) begin
        if (ec >= hold) begin
          ec = 0;
          creg[9] = mem_at(creg[8]);
          creg[8] = creg[8] + 32'd4;
          eack = 1;
        end else ec++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_valid = 1; hst_write = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_valid = 0; hst_write = 0;
    #1;
  endtask
  task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_valid = 1; hst_write = 0; hst_addr = a;
    #1 d = hst_rdata;
    @(negedge clk);
    hst_valid = 0;
    #1;
  endtask
  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      bus_rd(AST, s);
      if (!s[12]) break;
    end
  endtask
  task automatic reg_write(input logic [15:0] rn, input logic [31:0] v);
    bus_wr(AD0, v);
    bus_wr(ACM, mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b1, rn));
    wait_idle();
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    bus_rd(AST, rd); chk("R1 status", rd, 32'h0);
    bus_rd(AD0, rd); chk("R1 data0", rd, 32'h0);
    bus_rd(ACM, rd); chk("R1 command", rd, 32'h0);
    bus_rd(AAU, rd); chk("R1 autoexec", rd, 32'h0);
    chk("R1 requests", {30'd0, xreq, ereq}, 32'h0);

    // R2/R3/R5: directed write, then read back with busy observed
    bus_wr(AD0, 32'hA5A5_0001);
    bus_wr(ACM, mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b1, 16'h1002));
    chk("R2 xfer request after launch", {31'd0, xreq}, 32'd1);
    wait_idle();
    chk("R3 register written from data0", creg[2], 32'hA5A5_0001);
    hold = 3;
    bus_wr(AD0, 32'h0);
    bus_wr(ACM, mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 16'h1002));
    bus_rd(AST, rd); chk("R5 busy while ack pending", rd, st(1'b1, 3'd0));
    wait_idle();
    bus_rd(AST, rd); chk("R5 busy low after ack", rd, st(1'b0, 3'd0));
    bus_rd(AD0, rd); chk("R3 data0 captured from register", rd, 32'hA5A5_0001);

    // R3: random register round trips
    for (int i = 0; i < 8; i++) exp_reg[i] = 32'h0;
    exp_reg[2] = 32'hA5A5_0001;
    for (int it = 0; it < 30; it++) begin
      int r;
      r = int'($urandom_range(0, 7));
      hold = int'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) begin
        v = $urandom;
        reg_write({12'h100, r[3:0]}, v);
        exp_reg[r] = v;
      end else begin
        bus_wr(AD0, $urandom);
        bus_wr(ACM, mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, {12'h100, r[3:0]}));
        wait_idle();
        bus_rd(AD0, rd);
        chk("R3 random read back", rd, exp_reg[r]);
      end
    end
    bus_rd(AST, rd); chk("R3 no error after random run", rd, st(1'b0, 3'd0));

    // R6: auto-execute off, data0 access starts nothing
    hold = 0;
    bus_rd(AD0, rd);
    chk("R6 no launch with autoexec clear", {30'd0, xreq, ereq}, 32'h0);

    // R4/R7: two-deep memory stream
    reg_write(RS0, 32'h0000_0100);
    reg_write(RS1, 32'h5151_5151);
    bus_wr(ACM, mk(8'd0, 3'd2, 1'b1, 1'b1, 1'b0, RS1));
    wait_idle();
    bus_rd(AD0, rd); chk("R4 transfer before program buffer", rd, 32'h5151_5151);
    bus_wr(AAU, 32'h1);
    bus_rd(AAU, rd); chk("R6 autoexec readback", rd, 32'h1);
    for (int k = 1; k <= 6; k++) begin
      hold = int'($urandom_range(0, 2));
      bus_rd(AD0, rd);
      if (k == 1) chk("R7 first triggered read lags", rd, 32'h5151_5151);
      else chk("R7 stream word", rd, mem_at(32'h100 + 32'(4 * (k - 2))));
      wait_idle();
    end
    chk("R4 requests never overlap", overlap, 0);

    // R6: auto-execute on data0 write
    hold = 0;
    bus_wr(AAU, 32'h0);
    bus_wr(ACM, mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b1, 16'h1003));
    wait_idle();
    bus_wr(AAU, 32'h1);
    bus_wr(AD0, 32'hC0DE_0003);
    wait_idle();
    chk("R6 data0 write relaunches", creg[3], 32'hC0DE_0003);
    bus_wr(AAU, 32'h0);

    // R8: access while busy
    hold = 8;
    bus_wr(AD0, 32'h1111_2222);
    bus_wr(ACM, mk(8'd0, 3'd2, 1'b1, 1'b1, 1'b1, 16'h1004));
    bus_wr(AD0, 32'hDEAD_BEEF);
    wait_idle();
    bus_rd(AST, rd); chk("R8 busy error set", rd, st(1'b0, 3'd1));
    chk("R8 register got pre-busy data0", creg[4], 32'h1111_2222);
    bus_rd(AD0, rd); chk("R8 busy-time data0 write dropped", rd, 32'h1111_2222);

    // R9: sticky error blocks and clears by writing ones
    hold = 0;
    bus_wr(ACM, mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 16'h1004));
    chk("R9 no launch while error set", {30'd0, xreq, ereq}, 32'h0);
    bus_wr(AST, 32'h0);
    bus_rd(AST, rd); chk("R9 writing zero keeps error", rd, st(1'b0, 3'd1));
    bus_wr(AST, 32'h0000_0700);
    bus_rd(AST, rd); chk("R9 write ones clears", rd, st(1'b0, 3'd0));
    bus_wr(ACM, mk(8'd0, 3'd2, 1'b0, 1'b1, 1'b1, 16'h1005));
    chk("R9 relaunch after clear", {31'd0, xreq}, 32'd1);
    wait_idle();
    chk("R9 resumed command stored", creg[5], 32'h1111_2222);

    // R10: unsupported commands
    bus_wr(ACM, mk(8'd1, 3'd2, 1'b0, 1'b1, 1'b0, 16'h1000));
    chk("R10 bad type no request", {30'd0, xreq, ereq}, 32'h0);
    bus_rd(AST, rd); chk("R10 bad type code", rd, st(1'b0, 3'd2));
    bus_wr(AST, 32'h0000_0700);
    bus_wr(ACM, mk(8'd0, 3'd3, 1'b0, 1'b1, 1'b0, 16'h1000));
    bus_rd(AST, rd); chk("R10 bad size code", rd, st(1'b0, 3'd2));
    bus_wr(AST, 32'h0000_0700);
    bus_wr(ACM, mk(8'd0, 3'd3, 1'b1, 1'b0, 1'b0, 16'h1000));
    chk("R10 postexec-only runs", {30'd0, xreq, ereq}, 32'd1);
    wait_idle();
    bus_rd(AST, rd); chk("R10 postexec-only no error", rd, st(1'b0, 3'd0));

    finish_run();
  end
endmodule